// File: doc/BRIEF.md
# Toggle Handshake Clock-Domain Word Transfer

This block moves one multi-bit word at a time from a source clock domain into a destination clock domain whose clock has no fixed relation to the source clock. The source side takes a word through a valid/ready pair. It registers the word onto a shared data bus and flips a single request level. The destination side sees the flipped level after a chain of synchronizer flops. It copies the bus into its own register, raises a one-cycle valid strobe, and copies the request level onto its acknowledge line. The acknowledge returns through its own synchronizer. When it matches the request again, the source becomes ready for the next word.

Each edge of the request or acknowledge line marks one event. Neither line ever returns to zero between transfers, so a transfer costs one trip of each level through the synchronizers. Each domain has its own active-low reset input. That reset is applied asynchronously and released in step with that domain's clock.

Top module: `toggle_xfer_sync`

## Requirements
- R1: While either reset is applied and after it is released, with no word offered, `src_ready` is 1 and `dst_valid` is 0.
- R2: A word is accepted on a rising `src_clk` edge where `src_valid` and `src_ready` are both 1. `src_ready` is 0 in the cycle that follows.
- R3: While `src_ready` is 0, `src_valid` and `src_data` have no effect. No extra word is delivered, and the word in flight arrives unchanged.
- R4: Every accepted word appears exactly once on `dst_data` with `dst_valid` = 1, in acceptance order. The acknowledge level changes only on such a capture.
- R5: `dst_valid` is high for exactly one `dst_clk` cycle per transfer. `dst_data` keeps the last captured word until the next strobe.
- R6: `dst_valid` rises no more than SYNC_STAGES+2 `dst_clk` cycles after the accepting source edge.
- R7: After an acceptance, `src_ready` returns to 1 within the round trip of both synchronizers: at most SYNC_STAGES+3 destination cycles plus SYNC_STAGES+3 source cycles.
- R8: The shared bus and the request level stay constant for as long as `src_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain reset, active low, asynchronous assert |
| src_valid | input | 1 | Source offers a word |
| src_ready | output | 1 | Source side can take a word |
| src_data | input | DATA_W | Word offered by the source |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain reset, active low, asynchronous assert |
| dst_valid | output | 1 | One-cycle strobe marking a newly captured word |
| dst_data | output | DATA_W | Last captured word |

## Verification
A request and acknowledge pair that has fallen out of step shows up at the ports in one of two ways. Either `src_ready` stays low for good, which the round-trip bound catches within a few source cycles, or it returns with no strobe. A request edge that is detected twice, or a capture taken from a bus still changing, produces an extra, missing or wrong word on `dst_data`. The next strobe exposes it, because every 8-bit value is sent exactly once in a known arithmetic order. A strobe longer than one cycle, or a held word that drifts between strobes, is visible on the very next destination cycle.

// File: rtl/toggle_xfer_pkg.sv
`timescale 1ns/1ps
package toggle_xfer_pkg;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Synchronizer chains below two flops offer no metastability margin.
  function automatic int unsigned sync_depth(input int unsigned requested);
    return (requested < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : requested;
  endfunction
endpackage

// File: rtl/txs_level_sync.sv
`timescale 1ns/1ps
module txs_level_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/txs_src_side.sv
`timescale 1ns/1ps
module txs_src_side #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ack_seen,
  output logic              req_lvl,
  output logic [DATA_W-1:0] bus
);
  logic              req_q, req_d;
  logic [DATA_W-1:0] bus_q, bus_d;
  logic              take;

  // Idle when the returned acknowledge level has caught up with the request.
  assign in_ready = (req_q == ack_seen);
  assign take     = in_valid & in_ready;

  always_comb begin
    req_d = ~req_q;
    bus_d = in_data;
  end

  // Bus and request change on the same edge. The request reaches the
  // destination only after its synchronizer, so the bus has long settled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      bus_q <= '0;
    end else if (take) begin
      req_q <= req_d;
      bus_q <= bus_d;
    end
  end

  assign req_lvl = req_q;
  assign bus     = bus_q;
endmodule

// File: rtl/txs_dst_side.sv
`timescale 1ns/1ps
module txs_dst_side #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_seen,
  input  logic [DATA_W-1:0] bus,
  output logic              ack_lvl,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic              ack_q;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q;
  logic              edge_hit;

  assign edge_hit = req_seen ^ ack_q;

  always_comb begin
    valid_d = edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Capture the word and mirror the request level on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      data_q <= '0;
    end else if (edge_hit) begin
      ack_q  <= req_seen;
      data_q <= bus;
    end
  end

  assign ack_lvl   = ack_q;
  assign out_valid = valid_q;
  assign out_data  = data_q;
endmodule

// File: rtl/toggle_xfer_sync.sv
`timescale 1ns/1ps
module toggle_xfer_sync
  import toggle_xfer_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst_n,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic              dst_clk,
  input  logic              dst_rst_n,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data
);
  localparam int unsigned DEPTH = sync_depth(SYNC_STAGES);

  logic              src_rst_sn, dst_rst_sn;
  logic              xfer_req, xfer_ack;
  logic              req_sync, ack_sync;
  logic [DATA_W-1:0] xfer_bus;

  // Reset: asynchronous assert, release aligned to each local clock.
  txs_level_sync #(.STAGES(DEPTH)) u_src_rst (
    .clk(src_clk), .rst_n(src_rst_n), .d(1'b1), .q(src_rst_sn));
  txs_level_sync #(.STAGES(DEPTH)) u_dst_rst (
    .clk(dst_clk), .rst_n(dst_rst_n), .d(1'b1), .q(dst_rst_sn));

  txs_src_side #(.DATA_W(DATA_W)) u_src (
    .clk(src_clk), .rst_n(src_rst_sn),
    .in_valid(src_valid), .in_ready(src_ready), .in_data(src_data),
    .ack_seen(ack_sync), .req_lvl(xfer_req), .bus(xfer_bus));

  txs_level_sync #(.STAGES(DEPTH)) u_req_sync (
    .clk(dst_clk), .rst_n(dst_rst_sn), .d(xfer_req), .q(req_sync));

  txs_level_sync #(.STAGES(DEPTH)) u_ack_sync (
    .clk(src_clk), .rst_n(src_rst_sn), .d(xfer_ack), .q(ack_sync));

  txs_dst_side #(.DATA_W(DATA_W)) u_dst (
    .clk(dst_clk), .rst_n(dst_rst_sn),
    .req_seen(req_sync), .bus(xfer_bus), .ack_lvl(xfer_ack),
    .out_valid(dst_valid), .out_data(dst_data));
endmodule

// File: rtl/toggle_xfer_chk.sv
`timescale 1ns/1ps
module toggle_xfer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              src_clk,
  input logic              src_rst_sn,
  input logic              src_valid,
  input logic              src_ready,
  input logic              xfer_req,
  input logic [DATA_W-1:0] xfer_bus,
  input logic              dst_clk,
  input logic              dst_rst_sn,
  input logic              dst_valid,
  input logic              xfer_ack,
  input logic [DATA_W-1:0] dst_data
);
  a_r2_ready_drops: assert property (@(posedge src_clk) disable iff (!src_rst_sn)
    src_valid && src_ready |=> !src_ready);

  a_r8_bus_stable: assert property (@(posedge src_clk) disable iff (!src_rst_sn)
    !src_ready |=> $stable(xfer_bus));

  a_r3_req_holds: assert property (@(posedge src_clk) disable iff (!src_rst_sn)
    !src_ready |=> $stable(xfer_req));

  a_r5_single_pulse: assert property (@(posedge dst_clk) disable iff (!dst_rst_sn)
    dst_valid |=> !dst_valid);

  a_r5_data_hold: assert property (@(posedge dst_clk) disable iff (!dst_rst_sn)
    !dst_valid |-> $stable(dst_data));

  a_r4_ack_on_capture: assert property (@(posedge dst_clk) disable iff (!dst_rst_sn)
    !$stable(xfer_ack) |-> dst_valid);
endmodule

bind toggle_xfer_sync toggle_xfer_chk #(.DATA_W(DATA_W)) u_chk (
  .src_clk(src_clk), .src_rst_sn(src_rst_sn), .src_valid(src_valid),
  .src_ready(src_ready), .xfer_req(xfer_req), .xfer_bus(xfer_bus),
  .dst_clk(dst_clk), .dst_rst_sn(dst_rst_sn), .dst_valid(dst_valid),
  .xfer_ack(xfer_ack), .dst_data(dst_data));

// File: tb/tb_toggle_xfer_sync.sv
`timescale 1ns/1ps
module tb_toggle_xfer_sync;
  localparam int DW   = 8;
  localparam int SYNC = 2;
  localparam int NW   = 256;
  localparam int LAT_MAX = SYNC + 2;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n, dst_rst_n, src_valid, src_ready, dst_valid;
  logic [DW-1:0] src_data, dst_data;
  real dst_half = 3.5;

  toggle_xfer_sync #(.DATA_W(DW), .SYNC_STAGES(SYNC)) dut (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_valid(src_valid),
    .src_ready(src_ready), .src_data(src_data), .dst_clk(dst_clk),
    .dst_rst_n(dst_rst_n), .dst_valid(dst_valid), .dst_data(dst_data));

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  int checks = 0, failures = 0;
  logic [DW-1:0] exp_mem [0:NW-1];
  int wr_i, rd_i, since_acc, cyc = 0;
  bit pending, mon_en = 0, done = 0;
  logic prev_valid;
  logic [DW-1:0] last_rx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge src_clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      failures++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", rd_i, wr_i);
      report();
      $finish;
    end
  end

  // Destination monitor, sampled away from the active edge.
  always @(negedge dst_clk) begin
    if (mon_en) begin
      if (pending) since_acc++;
      if (dst_valid) begin
        if (rd_i >= wr_i) chk(1'b0, "R3 extra word", int'(dst_data), -1);
        else begin
          chk(dst_data == exp_mem[rd_i], "R4 R8 word order/value", int'(dst_data), int'(exp_mem[rd_i]));
          rd_i++;
        end
        chk(since_acc <= LAT_MAX, "R6 latency", since_acc, LAT_MAX);
        pending = 1'b0;
        chk(prev_valid == 1'b0, "R5 strobe width", int'(prev_valid), 0);
        last_rx = dst_data;
      end else if (rd_i > 0) begin
        chk(dst_data == last_rx, "R5 hold", int'(dst_data), int'(last_rx));
      end
      prev_valid = dst_valid;
    end
  end

  task automatic do_reset(input real half);
    mon_en = 1'b0;
    src_valid = 1'b0; src_data = '0;
    src_rst_n = 1'b0; dst_rst_n = 1'b0;
    dst_half = half;
    #37;
    chk(src_ready == 1'b1, "R1 ready in reset", int'(src_ready), 1);
    chk(dst_valid == 1'b0, "R1 valid in reset", int'(dst_valid), 0);
    src_rst_n = 1'b1; dst_rst_n = 1'b1;
    wr_i = 0; rd_i = 0; pending = 1'b0; prev_valid = 1'b0; last_rx = '0;
    repeat (6) @(negedge src_clk);
    repeat (6) @(negedge dst_clk);
    @(negedge src_clk);
    chk(src_ready == 1'b1, "R1 ready after reset", int'(src_ready), 1);
    chk(dst_valid == 1'b0, "R1 valid after reset", int'(dst_valid), 0);
    mon_en = 1'b1;
  endtask

  task automatic send(input logic [DW-1:0] w, input bit junk, input int rt_max);
    int waitc;
    exp_mem[wr_i] = w;
    wr_i++;
    while (!src_ready) @(negedge src_clk);
    src_valid = 1'b1; src_data = w;
    @(negedge src_clk);
    since_acc = 0; pending = 1'b1;
    chk(src_ready == 1'b0, "R2 ready drops", int'(src_ready), 0);
    waitc = 0;
    // R3: offer a different word while busy; it must be ignored.
    src_valid = junk; src_data = w ^ 8'h5A;
    while (!src_ready && waitc < 1000) begin
      @(negedge src_clk);
      waitc++;
    end
    src_valid = 1'b0;
    chk(waitc <= rt_max, "R7 round trip", waitc, rt_max);
  endtask

  initial begin
    real halves [3];
    halves[0] = 3.5; halves[1] = 8.0; halves[2] = 23.0;
    src_valid = 1'b0; src_data = '0; src_rst_n = 1'b0; dst_rst_n = 1'b0;
    for (int c = 0; c < 3; c++) begin
      int rt_max, guard;
      rt_max = ((SYNC + 3) * int'(halves[c] * 20.0) + 99) / 100 + SYNC + 3;
      do_reset(halves[c]);
      for (int i = 0; i < NW; i++) begin
        logic [DW-1:0] w;
        w = DW'((i * 73 + c * 29) % 256);
        send(w, (i % 2) == 1, rt_max);
        if (i % 3 == 0) repeat (i % 5) @(negedge src_clk);
      end
      guard = 0;
      while (rd_i < wr_i && guard < 300) begin
        @(negedge src_clk);
        guard++;
      end
      repeat (10) @(negedge dst_clk);
      chk(rd_i == NW, "R4 delivered count", rd_i, NW);
      chk(src_ready == 1'b1, "R7 idle at end", int'(src_ready), 1);
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule